// File: doc/BRIEF.md
# Two-Grant Burst Memory Client

This block is the client side of a shared memory controller. It moves one burst of data words to or from memory, and it gets access through an arbiter that gives out two grants in turn. The user side starts a transfer with a one-cycle read or write strobe. The strobe comes with a start address and a burst length. The block then raises a single request pulse and waits for the first grant.

After the first grant, the block puts a two-beat command on a shared 36-bit info bus: the address first, then the length together with the operation type. It then waits for the second grant and streams the burst, one word per cycle. Both grant inputs pass through a register before the sequencer uses them.

While a transfer is running, the block ignores further start strobes. It reports the end of the burst with a one-cycle done pulse. The memory controller and the arbiter are not part of the block.

Top module: `burst_client`

## Requirements
- R1: After reset, `req`, `busy`, `done`, `mem_rd_en`, `mem_wr_en`, `rd_valid` and `wr_take` are 0, and `info_bus` is all zeros.
- R2: When the block is idle and a start strobe is sampled at a clock edge, `req` is 1 for exactly the following clock cycle and 0 afterwards.
- R3: A start strobe with `start_rd` at 1 gives a read. A start strobe with only `start_wr` at 1 gives a write. When both are 1 in the same cycle, the read wins.
- R4: Each grant input is taken through one register. A grant pulse of a single cycle, given at any time from the `req` cycle onward, is enough to advance the block.
- R5: Two cycles after the cycle in which `grant1` is high, `info_bus` carries the start address, zero-extended, for one cycle.
- R6: In the next cycle, `info_bus` carries the length beat for one cycle. Bits 7:0 hold the burst length, bit 8 holds the operation (1 = read, 0 = write), and all other bits are 0. Outside these two beats, `info_bus` is 0.
- R7: No data beat happens before the registered second grant. The first data beat falls in the cycle after the cycle in which `grant2` is high.
- R8: A burst has as many beats as the length field says, on consecutive cycles, with a length of 0 meaning 256 words.
- R9: On a write beat, `wr_take` and `mem_wr_en` are 1 and `mem_wdata` equals `wr_word`. On a read beat, `mem_rd_en` and `rd_valid` are 1 and `rd_word` equals `mem_rdata`.
- R10: `busy` is 1 from the `req` cycle up to the last data beat, and 0 when the block is idle.
- R11: `done` is 1 for exactly one cycle, the cycle after the last data beat, and the block is idle in that cycle.
- R12: Start strobes that arrive while `busy` is 1 have no effect. The running burst finishes unchanged, and no new request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_rd | input | 1 | One-cycle strobe that starts a read burst |
| start_wr | input | 1 | One-cycle strobe that starts a write burst |
| start_addr | input | ADDR_W | Burst start address, sampled with the strobe |
| start_len | input | 8 | Burst length in words, 0 meaning 256 |
| req | output | 1 | One-cycle access request to the arbiter |
| grant1 | input | 1 | First grant from the arbiter |
| grant2 | input | 1 | Second grant from the arbiter |
| info_bus | output | 36 | Command beats: address, then length and operation |
| wr_word | input | DATA_W | Next write word from the user side |
| wr_take | output | 1 | The user's write word is consumed this cycle |
| mem_wdata | output | DATA_W | Write data to the controller |
| mem_wr_en | output | 1 | Write data beat |
| mem_rdata | input | DATA_W | Read data from the controller |
| mem_rd_en | output | 1 | Read data beat |
| rd_word | output | DATA_W | Read word to the user side |
| rd_valid | output | 1 | `rd_word` is valid this cycle |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse when a burst has finished |

## Verification
The assertions assume that the arbiter grants only a client that has asked for access. They also assume that `grant1` comes only after the request and `grant2` only after the length beat, so that the sequencer never meets a grant it did not expect. The stimulus works as a grant-side model that watches `req` and the length beat on the info bus. It answers each with one grant pulse after a random delay of zero to four cycles, and it never holds a grant outside those windows. Start strobes inside a transfer are injected on purpose, because R12 requires the block to ignore them.

// File: rtl/burst_client_pkg.sv
package burst_client_pkg;

    localparam int INFO_W = 36;
    localparam int LEN_W  = 8;
    localparam int OP_BIT = LEN_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT_G1,
        ST_ADDR,
        ST_WAIT_G2,
        ST_XFER
    } fsm_e;

    typedef enum logic {
        OP_WRITE = 1'b0,
        OP_READ  = 1'b1
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [LEN_W-1:0] len;
    } cmd_t;

    function automatic logic [INFO_W-1:0] len_beat(cmd_t c);
        logic [INFO_W-1:0] b;
        b = '0;
        b[LEN_W-1:0] = c.len;
        b[OP_BIT]    = c.op;
        return b;
    endfunction

endpackage

// File: rtl/grant_sync.sv
module grant_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] g_in,
    output logic [N-1:0] g_q
);
    for (genvar i = 0; i < N; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) g_q[i] <= 1'b0;
            else     g_q[i] <= g_in[i];
        end
    end
endmodule

// File: rtl/word_counter.sv
module word_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         last
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= load_val;
        else if (dec)  cnt <= cnt - 1'b1;
    end

    assign last = (cnt == W'(1));

    // R8
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (dec && !load) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/burst_client.sv
module burst_client
    import burst_client_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_rd,
    input  logic              start_wr,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  start_len,
    output logic              req,
    input  logic              grant1,
    input  logic              grant2,
    output logic [INFO_W-1:0] info_bus,
    input  logic [DATA_W-1:0] wr_word,
    output logic              wr_take,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_wr_en,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rd_en,
    output logic [DATA_W-1:0] rd_word,
    output logic              rd_valid,
    output logic              busy,
    output logic              done
);
    fsm_e              state, state_nx;
    cmd_t              cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        g_q;
    logic              g1_q, g2_q;
    logic              accept, beat, last;
    logic              req_q, done_q;
    logic [INFO_W-1:0] info_q;

    grant_sync #(.N(2)) i_grant_sync (
        .clk  (clk),
        .rst  (rst),
        .g_in ({grant2, grant1}),
        .g_q  (g_q)
    );
    assign g1_q = g_q[0];
    assign g2_q = g_q[1];

    assign accept = (state == ST_IDLE) && (start_rd || start_wr);
    assign beat   = ((state == ST_WAIT_G2) && g2_q) || (state == ST_XFER);

    word_counter #(.W(LEN_W)) i_word_counter (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (start_len),
        .dec      (beat),
        .last     (last)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (accept) state_nx = ST_REQ;
            ST_REQ:     state_nx = ST_WAIT_G1;
            ST_WAIT_G1: if (g1_q) state_nx = ST_ADDR;
            ST_ADDR:    state_nx = ST_WAIT_G2;
            ST_WAIT_G2: if (g2_q) state_nx = last ? ST_IDLE : ST_XFER;
            ST_XFER:    if (last) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cmd_q  <= '0;
            addr_q <= '0;
            req_q  <= 1'b0;
            done_q <= 1'b0;
            info_q <= '0;
        end else begin
            state  <= state_nx;
            req_q  <= accept;
            done_q <= beat && last;
            info_q <= '0;
            if (accept) begin
                cmd_q.op  <= start_rd ? OP_READ : OP_WRITE;
                cmd_q.len <= start_len;
                addr_q    <= start_addr;
            end
            if (state == ST_WAIT_G1 && g1_q) info_q <= INFO_W'(addr_q);
            if (state == ST_ADDR)            info_q <= len_beat(cmd_q);
        end
    end

    assign req       = req_q;
    assign done      = done_q;
    assign busy      = (state != ST_IDLE);
    assign info_bus  = info_q;
    assign mem_wr_en = beat && (cmd_q.op == OP_WRITE);
    assign wr_take   = mem_wr_en;
    assign mem_wdata = wr_word;
    assign mem_rd_en = beat && (cmd_q.op == OP_READ);
    assign rd_valid  = mem_rd_en;
    assign rd_word   = mem_rdata;

    // R2
    req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        req |=> !req);

    // R12
    req_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
        req |-> $past(state == ST_IDLE));

    // R5
    addr_after_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ADDR) |-> $past(g1_q));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R7
    beat_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en || mem_wr_en) |-> (g2_q || $past(mem_rd_en || mem_wr_en)));
endmodule

// File: tb/test_burst_client.sv
module test_burst_client;
    localparam int ADDR_W = 24;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_rd = 1'b0, start_wr = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic [7:0]        start_len = '0;
    logic              req, grant1 = 1'b0, grant2 = 1'b0;
    logic [35:0]       info_bus;
    logic [DATA_W-1:0] wr_word = '0, mem_wdata, mem_rdata = '0, rd_word;
    logic              wr_take, mem_wr_en, mem_rd_en, rd_valid, busy, done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    burst_client #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_burst_client (
        .clk(clk), .rst(rst), .start_rd(start_rd), .start_wr(start_wr),
        .start_addr(start_addr), .start_len(start_len), .req(req),
        .grant1(grant1), .grant2(grant2), .info_bus(info_bus),
        .wr_word(wr_word), .wr_take(wr_take), .mem_wdata(mem_wdata),
        .mem_wr_en(mem_wr_en), .mem_rdata(mem_rdata), .mem_rd_en(mem_rd_en),
        .rd_word(rd_word), .rd_valid(rd_valid), .busy(busy), .done(done)
    );

    always #4 clk = ~clk;

    function automatic logic [35:0] exp_len_beat(bit rd, logic [7:0] len);
        logic [35:0] b = '0;
        b[7:0] = len;
        b[8]   = rd;
        return b;
    endfunction

    function automatic int exp_words(logic [7:0] len);
        return (len == 8'd0) ? 256 : int'(len);
    endfunction

    function automatic logic [DATA_W-1:0] word_pat(int seq, int i);
        return DATA_W'(32'h5A000000 ^ (seq << 12) ^ i);
    endfunction

    task automatic chk(bit ok, string req_tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req_tag, act, exp, $time);
        end
    endtask

    task automatic chk_quiet(string req_tag);
        chk(!mem_rd_en && !mem_wr_en && !rd_valid && !wr_take, req_tag,
            {mem_rd_en, mem_wr_en, rd_valid, wr_take}, 0);
    endtask

    // One full burst; both=1 raises both strobes, stray=1 injects starts mid-transfer.
    task automatic run_burst(int seq, bit rd, bit both, logic [ADDR_W-1:0] addr,
                             logic [7:0] len, int d1, int d2, bit stray);
        bit exp_rd;
        int n;
        exp_rd = rd || both;
        n = exp_words(len);
        @(negedge clk);
        start_rd = rd || both; start_wr = !rd || both;
        start_addr = addr; start_len = len;
        @(negedge clk);
        start_rd = 1'b0; start_wr = 1'b0;
        chk(req == 1'b1, "R2", req, 1);
        chk(busy == 1'b1, "R10", busy, 1);
        for (int k = 0; k < d1; k++) begin
            @(negedge clk);
            chk(req == 1'b0, "R2", req, 0);
            chk(info_bus == '0, "R6", info_bus, 0);
            if (stray && k == 0) begin
                start_wr = 1'b1; start_rd = 1'b1; start_addr = ~addr; start_len = len + 8'd3;
            end else begin
                start_wr = 1'b0; start_rd = 1'b0;
            end
        end
        grant1 = 1'b1;
        @(negedge clk);
        grant1 = 1'b0; start_wr = 1'b0; start_rd = 1'b0;
        chk(info_bus == '0, "R4", info_bus, 0);
        @(negedge clk);
        chk(info_bus == 36'(addr), "R5", info_bus, 36'(addr));
        if (stray) begin start_rd = 1'b1; start_addr = ~addr; end
        @(negedge clk);
        start_rd = 1'b0;
        chk(info_bus == exp_len_beat(exp_rd, len), "R6", info_bus, exp_len_beat(exp_rd, len));
        chk(info_bus[8] == exp_rd, "R3", info_bus[8], exp_rd);
        for (int k = 0; k < d2; k++) begin
            chk_quiet("R7");
            @(negedge clk);
            chk(info_bus == '0, "R6", info_bus, 0);
        end
        chk_quiet("R7");
        grant2 = 1'b1;
        @(negedge clk);
        grant2 = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (exp_rd) begin
                mem_rdata = word_pat(seq, i);
                #1;
                chk(mem_rd_en && rd_valid && !mem_wr_en && !wr_take, "R9",
                    {mem_rd_en, rd_valid, mem_wr_en, wr_take}, 4'b1100);
                chk(rd_word == word_pat(seq, i), "R9", rd_word, word_pat(seq, i));
            end else begin
                wr_word = word_pat(seq, i);
                #1;
                chk(mem_wr_en && wr_take && !mem_rd_en && !rd_valid, "R9",
                    {mem_wr_en, wr_take, mem_rd_en, rd_valid}, 4'b1100);
                chk(mem_wdata == word_pat(seq, i), "R9", mem_wdata, word_pat(seq, i));
            end
            chk(busy == 1'b1, "R10", busy, 1);
            chk(done == 1'b0, "R11", done, 0);
            if (stray && i == 0) start_wr = 1'b1;
            @(negedge clk);
            start_wr = 1'b0;
        end
        chk_quiet("R8");
        chk(done == 1'b1, "R11", done, 1);
        chk(busy == 1'b0, "R10", busy, 0);
        @(negedge clk);
        chk(done == 1'b0, "R11", done, 0);
        chk(req == 1'b0, "R12", req, 0);
        chk(busy == 1'b0, "R12", busy, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 7;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!req && !busy && !done && !mem_rd_en && !mem_wr_en && !rd_valid && !wr_take,
            "R1", {req, busy, done, mem_rd_en, mem_wr_en, rd_valid, wr_take}, 0);
        chk(info_bus == '0, "R1", info_bus, 0);
        // directed corner cases
        run_burst(1, 1'b1, 1'b0, 24'h00ABCD, 8'd1, 0, 0, 1'b0);
        run_burst(2, 1'b0, 1'b0, 24'hFFFFFF, 8'd1, 3, 2, 1'b0);
        run_burst(3, 1'b0, 1'b1, 24'h123456, 8'd4, 1, 0, 1'b0);  // R3 both strobes
        run_burst(4, 1'b0, 1'b0, 24'h000010, 8'd0, 2, 1, 1'b0);  // R8 256 words
        run_burst(5, 1'b1, 1'b0, 24'h0F0F0F, 8'd5, 2, 3, 1'b1);  // R12 stray starts
        // constrained random
        for (int t = 0; t < 40; t++) begin
            bit rd;
            logic [ADDR_W-1:0] a;
            logic [7:0] l;
            rd = 1'($urandom_range(0, 1));
            a  = ADDR_W'($urandom);
            l  = 8'($urandom_range(1, 20));
            run_burst(10 + t, rd, 1'b0, a, l, int'($urandom_range(0, 4)),
                      int'($urandom_range(0, 4)), ($urandom_range(0, 3) == 0) ? 1'b1 : 1'b0);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule